// File: doc/BRIEF.md
# Flagged Run-Length Sample Encoder

This block sits between the sampling front end of a logic analyzer and its capture memory. Every accepted sample becomes zero, one or two output words of the same width as the sample. The top bit of each output word tells a data word from a repeat-count word. A sample whose value differs from the one before is sent out unchanged as a data word. A run of identical samples is sent as the value once, followed by one count word that holds the number of extra repeats. A sample stream with no repeats therefore passes through word for word, and the output never carries more words than the input carried samples, apart from the deferred count.

The lower bits of a count word form a saturating counter one bit narrower than the word. When the counter reaches its all-ones value, that count is sent at once and counting starts again on the same value, without sending the value a second time. At the end of a capture, a flush input closes the open run. It sends any pending count and clears the remembered value. The flag bit also lets a downstream circular buffer recognise, and drop, a count word that has lost the data word before it.

Samples arrive with a valid strobe and are accepted only while `smp_ready` is high. Output words leave through a valid/ready handshake, buffered by a small internal queue.

Top module: `rle_flag_encoder`

## Requirements
- R1: Output bit W-1 is the flag: 0 marks a data word, 1 marks a count word. A data word carries the sample's bits W-2..0 in its bits W-2..0. A count word carries the repeat count in bits W-2..0.
- R2: When every accepted sample differs from the one before, only data words are emitted, one per sample, and no count word appears.
- R3: A run of N+1 identical samples (N ≥ 1) produces the data word and then one count word of value N. The count word is emitted when a differing sample arrives, before that sample's data word, or on flush. A count word with value zero is never emitted, and nothing is emitted in a cycle with no accepted sample and no flush.
- R4: Samples are compared on bits W-2..0 only. Two samples that differ only in bit W-1 count as a repeat.
- R5: When the run count reaches 2^(W-1)-1, a count word of that value is emitted in the same cycle and the count restarts at zero. The value is not sent again, so later repeats form further count words.
- R6: Flush emits the pending count word if the count is nonzero, and emits nothing otherwise. After a flush, the next sample is emitted as a data word even if it equals the last value.
- R7: While flush is high, `smp_ready` is low and no sample is taken.
- R8: Words leave in the order they were produced. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold steady.
- R9: `smp_ready` is low whenever fewer than two queue slots are free, so the queue never overflows. After reset, `out_valid` is low and `smp_ready` is high.
- R10: The first sample after reset is emitted as a data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | W | Sample value |
| smp_ready | output | 1 | Encoder can take a sample this cycle |
| flush | input | 1 | Close the open run at capture end |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | W | Flagged data or count word |

## Verification
The case hardest to reach from the ports is counter saturation. With the default 8-bit word, it takes 128 identical samples in a row before the counter wraps. The bench drives runs of exactly 128 and 130 identical samples, then flushes. This shows that a saturated count is emitted without a second copy of the value, and that the leftover repeats form their own count word. Queue back-pressure is reached by holding `out_ready` low until `smp_ready` drops, then releasing it and checking that the word order is intact.

// File: rtl/rle_pkg.sv
package rle_pkg;
  // meaning of the flag bit on each output word
  typedef enum logic {
    KIND_DATA  = 1'b0,
    KIND_COUNT = 1'b1
  } word_kind_e;

  // number of words the run tracker hands to the queue in one cycle
  typedef logic [1:0] push_cnt_t;
endpackage

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_go,
  input  logic [W-1:0]    smp_data,
  input  logic            flush_go,
  output push_cnt_t       push_cnt,
  output logic [W-1:0]    push_w0,
  output logic [W-1:0]    push_w1,
  output logic            sat_evt
);
  localparam int CW = W - 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  function automatic logic [CW-1:0] payload(input logic [W-1:0] s);
    return s[CW-1:0];
  endfunction

  function automatic logic [W-1:0] data_word(input logic [CW-1:0] v);
    return {KIND_DATA, v};
  endfunction

  function automatic logic [W-1:0] count_word(input logic [CW-1:0] c);
    return {KIND_COUNT, c};
  endfunction

  logic            have_last_q, have_last_d;
  logic [CW-1:0]   last_q, last_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CW-1:0]   masked;
  logic            same;

  assign masked = payload(smp_data);
  assign same   = have_last_q && (masked == last_q);

  always_comb begin
    have_last_d = have_last_q;
    last_d      = last_q;
    cnt_d       = cnt_q;
    push_cnt    = 2'd0;
    push_w0     = '0;
    push_w1     = '0;
    sat_evt     = 1'b0;
    if (flush_go) begin
      if (cnt_q != '0) begin
        push_cnt = 2'd1;
        push_w0  = count_word(cnt_q);
      end
      have_last_d = 1'b0;
      cnt_d       = '0;
    end else if (smp_go) begin
      if (!have_last_q) begin
        push_cnt    = 2'd1;
        push_w0     = data_word(masked);
        have_last_d = 1'b1;
        last_d      = masked;
        cnt_d       = '0;
      end else if (same) begin
        if (cnt_q == CNT_MAX - CW'(1)) begin
          push_cnt = 2'd1;
          push_w0  = count_word(CNT_MAX);
          sat_evt  = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q != '0) begin
          push_cnt = 2'd2;
          push_w0  = count_word(cnt_q);
          push_w1  = data_word(masked);
        end else begin
          push_cnt = 2'd1;
          push_w0  = data_word(masked);
        end
        last_d = masked;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last_q <= 1'b0;
      last_q      <= '0;
      cnt_q       <= '0;
    end else begin
      have_last_q <= have_last_d;
      last_q      <= last_d;
      cnt_q       <= cnt_d;
    end
  end
endmodule

// File: rtl/rle_word_fifo.sv
module rle_word_fifo
  import rle_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  push_cnt_t                    wr_cnt,
  input  logic [W-1:0]                 wr_w0,
  input  logic [W-1:0]                 wr_w1,
  input  logic                         rd_pop,
  output logic                         rd_valid,
  output logic [W-1:0]                 rd_word,
  output logic [$clog2(DEPTH+1)-1:0]   free_slots,
  output logic                         ovf_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [OW-1:0] occ;
  logic [OW:0]   occ_sum;
  logic          pop;

  assign pop        = rd_pop && (occ != '0);
  assign rd_valid   = (occ != '0);
  assign rd_word    = mem[rp];
  assign free_slots = OW'(DEPTH) - occ;
  assign occ_sum    = {1'b0, occ} + (OW + 1)'(wr_cnt);
  assign ovf_evt    = occ_sum > (OW + 1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (wr_cnt != 2'd0) mem[wp] <= wr_w0;
    if (wr_cnt == 2'd2) mem[wp + AW'(1)] <= wr_w1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      wp  <= wp + AW'(wr_cnt);
      if (pop) rp <= rp + AW'(1);
      occ <= occ + OW'(wr_cnt) - OW'(pop);
    end
  end
endmodule

// File: rtl/rle_flag_encoder.sv
module rle_flag_encoder
  import rle_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  output logic         smp_ready,
  input  logic         flush,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  localparam int OW = $clog2(DEPTH + 1);

  logic            room;
  logic            smp_go;
  logic            flush_go;
  push_cnt_t       trk_cnt;
  logic [W-1:0]    trk_w0, trk_w1;
  logic            sat_evt;
  logic [OW-1:0]   free_slots;
  logic            fifo_ovf;

  assign room      = free_slots >= OW'(2);
  assign smp_ready = room && !flush;
  assign smp_go    = smp_valid && smp_ready;
  assign flush_go  = flush && room;

  rle_run_tracker #(.W(W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_go   (smp_go),
    .smp_data (smp_data),
    .flush_go (flush_go),
    .push_cnt (trk_cnt),
    .push_w0  (trk_w0),
    .push_w1  (trk_w1),
    .sat_evt  (sat_evt)
  );

  rle_word_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cnt     (trk_cnt),
    .wr_w0      (trk_w0),
    .wr_w1      (trk_w1),
    .rd_pop     (out_ready),
    .rd_valid   (out_valid),
    .rd_word    (out_word),
    .free_slots (free_slots),
    .ovf_evt    (fifo_ovf)
  );
endmodule

// File: rtl/rle_flag_encoder_chk.sv
module rle_flag_encoder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_word,
  input logic         fifo_ovf,
  input logic [1:0]   trk_cnt,
  input logic         smp_go,
  input logic         flush_go,
  input logic         sat_evt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R8

  AST_VALID_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_cnt != 2'd0) |=> out_valid); // R8

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[W-1]) |-> (out_word[W-2:0] != '0)); // R3

  AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_go && !flush_go) |-> (trk_cnt == 2'd0)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ovf); // R9

  AST_SAT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> (smp_go && trk_cnt == 2'd1)); // R5
endmodule

bind rle_flag_encoder rle_flag_encoder_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .fifo_ovf  (fifo_ovf),
  .trk_cnt   (trk_cnt),
  .smp_go    (smp_go),
  .flush_go  (flush_go),
  .sat_evt   (sat_evt)
);

// File: tb/sim_rle_flag_encoder.sv
`timescale 1ns/1ps
module sim_rle_flag_encoder;
  localparam int W = 8;
  localparam int NSTIM = 10;
  localparam int NEXP  = 9;
  // stimulus samples and the words they must produce (R1 R2 R3 R4 R10)
  localparam logic [7:0] STIM [NSTIM] = '{8'h05, 8'h05, 8'h09, 8'h0A, 8'h0A,
                                          8'h0A, 8'h0B, 8'h0B, 8'hF3, 8'h73};
  localparam logic [7:0] EXPW [NEXP]  = '{8'h05, 8'h81, 8'h09, 8'h0A, 8'h82,
                                          8'h0B, 8'h81, 8'h73, 8'h81};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic smp_ready;
  logic flush = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] got [512];
  int n_got = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rle_flag_encoder #(.W(W), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && n_got < 512) begin
      got[n_got] = out_word;
      n_got = n_got + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] v);
    smp_valid = 1'b1;
    smp_data  = v;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      report();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset smp_ready", 32'(smp_ready), 32'd1);

    // table walk: R1 R2 R3 R4 R10
    base = n_got;
    for (int i = 0; i < NSTIM; i++) send(STIM[i]);
    do_flush();
    settle();
    chk("R3 table word count", 32'(n_got - base), 32'(NEXP));
    for (int i = 0; i < NEXP; i++) chk("R1/R3/R4 table word", 32'(got[base + i]), 32'(EXPW[i]));

    // R2: all distinct, data words only
    base = n_got;
    for (int i = 0; i < 6; i++) send(8'(8'h30 + 2 * i));
    do_flush();
    settle();
    chk("R2 distinct count", 32'(n_got - base), 32'd6);
    for (int i = 0; i < 6; i++) chk("R2 distinct word", 32'(got[base + i]), 32'(8'h30 + 2 * i));

    // R5: exactly 128 equal samples, saturated count then flush emits nothing (R6)
    base = n_got;
    for (int i = 0; i < 128; i++) send(8'h11);
    do_flush();
    settle();
    chk("R5 sat128 count", 32'(n_got - base), 32'd2);
    chk("R5 sat128 w0", 32'(got[base]), 32'h11);
    chk("R5 sat128 w1", 32'(got[base + 1]), 32'hFF);

    // R5: 130 equal samples -> value, 127, 2
    base = n_got;
    for (int i = 0; i < 130; i++) send(8'h11);
    do_flush();
    settle();
    chk("R5/R6 sat130 count", 32'(n_got - base), 32'd3);
    chk("R6 data after flush", 32'(got[base]), 32'h11);
    chk("R5 sat130 w1", 32'(got[base + 1]), 32'hFF);
    chk("R5 sat130 w2", 32'(got[base + 2]), 32'h82);

    // R8/R9: back-pressure
    base = n_got;
    out_ready = 1'b0;
    send(8'h21);
    send(8'h22);
    send(8'h23);
    chk("R9 ready low near full", 32'(smp_ready), 32'd0);
    chk("R8 head valid", 32'(out_valid), 32'd1);
    chk("R8 head word", 32'(out_word), 32'h21);
    repeat (3) @(negedge clk);
    chk("R8 head held", 32'(out_word), 32'h21);
    out_ready = 1'b1;
    settle();
    chk("R8 order count", 32'(n_got - base), 32'd3);
    chk("R8 order w0", 32'(got[base]), 32'h21);
    chk("R8 order w1", 32'(got[base + 1]), 32'h22);
    chk("R8 order w2", 32'(got[base + 2]), 32'h23);

    // R7: sample during flush is not taken; R6: next equal sample re-sent as data
    base = n_got;
    flush = 1'b1;
    smp_valid = 1'b1;
    smp_data = 8'h23;
    #1;
    chk("R7 ready low in flush", 32'(smp_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    smp_valid = 1'b0;
    settle();
    chk("R7/R6 nothing emitted", 32'(n_got - base), 32'd0);
    send(8'h23);
    settle();
    chk("R6 resend count", 32'(n_got - base), 32'd1);
    chk("R6 resend data", 32'(got[base]), 32'h23);

    done = 1'b1;
    report();
  end
endmodule